// File: doc/BRIEF.md
# Extended-Range Capture Period Meter

This block measures the interval between consecutive rising edges of an asynchronous capture input. A 16-bit counter advances on each cycle in which a tick enable is high. It climbs from zero to a programmable reload value and then returns to zero, so each lap lasts reload + 1 ticks. Between two edges the block keeps a record of the laps completed. On each edge it outputs a 32-bit period that already includes every lap, together with a single-cycle valid strobe.

When an edge and a counter wrap fall in the same cycle, the hardware settles their order. The captured value is the pre-wrap count, and that wrap is charged to the following interval. The result stays exact with the counter running at all times, and software never has to stop it or reason about lap counts. A small register port exposes the reload value, the last captured count, the live count and a status word. Each status flag is cleared by writing zero to its bit, and writing one leaves it alone.

Top module: `period_meter`

## Requirements
- R1: The counter changes only on cycles with `tick_en` high. On such a cycle it returns to 0 when its value is at or above the reload value and otherwise adds one. With `tick_en` low it holds.
- R2: `cap_in` passes through a two-flop synchroniser and a rising-edge detector. The capture register (address 2) takes the counter value of the cycle in which the edge is detected. Falling edges produce no capture and no strobe.
- R3: On a detected edge, `period_o` becomes (reload + 1) × wraps since the previous edge + captured value − previous captured value, which equals the ticks between the two detected edges. `period_valid_o` pulses for one cycle, three rising clock edges after `cap_in` goes high.
- R4: When a capture and a wrap fall in the same cycle, the capture takes the pre-wrap value. The wrap is left out of the current period and counted as the first wrap of the next interval, so the next period stays exact.
- R5: The first edge after reset only records the previous capture and gives no valid strobe. Every later edge gives exactly one single-cycle strobe.
- R6: Status sits at address 1, with the wrap flag at bit 0, the capture flag at bit 4 and the saturation flag at bit 5. Writing a 0 to a flag bit clears it and writing a 1 leaves it unchanged, so writing 0xFFFE clears only bit 0 and writing 0xFFEF clears only bit 4.
- R7: A flag that hardware sets in the same cycle as a software clear stays set.
- R8: If more than 65535 wraps would be counted in one interval, status bit 5 is set and that interval's period reads as 0xFFFFFFFF.
- R9: After reset the counter, the capture register, the previous capture and all flags are 0, and the reload value is 0xFFFF.
- R10: Address 0 holds the reload value and can be both written and read. Address 3 reads the live counter value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tick_en | input | 1 | Counter advance enable |
| cap_in | input | 1 | Asynchronous capture input |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register select: 0 reload, 1 status, 2 capture, 3 count |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Register read data, combinational on `reg_addr` |
| period_o | output | 32 | Last measured period in ticks |
| period_valid_o | output | 1 | One-cycle strobe marking a new period |

## Verification
The checker assumes two things about the inputs. First, `cap_in` holds each level for at least two clock cycles, so that no two detected edges fall in adjacent cycles. Second, register writes go only to the four defined addresses. The stimulus holds each capture pulse high for at least three cycles and low for at least three. It changes the reload value only while the counter is idle after a reset, so a captured value can be predicted as the bench tick count modulo reload + 1. The gap sweeps are run with a steady tick and with a pseudo-random tick pattern, and they place edges on every counter phase, including the cycle of a wrap.

// File: rtl/pm_pkg.sv
package pm_pkg;

    typedef enum logic [1:0] {
        SEL_RELOAD  = 2'd0,
        SEL_STATUS  = 2'd1,
        SEL_CAPTURE = 2'd2,
        SEL_COUNT   = 2'd3
    } reg_sel_e;

    // Status word bit positions.
    localparam int FLAG_WRAP = 0;
    localparam int FLAG_CAP  = 4;
    localparam int FLAG_SAT  = 5;

endpackage

// File: rtl/pm_edge_sync.sv
module pm_edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_i,
    output logic rise_o
);
    localparam int DEPTH = STAGES + 1;

    logic [DEPTH-1:0] sh_d, sh_q;

    always_comb begin
        sh_d = {sh_q[DEPTH-2:0], async_i};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh_q <= '0;
        else        sh_q <= sh_d;
    end

    // Last synchronised sample high, the one before it low.
    assign rise_o = sh_q[STAGES-1] & ~sh_q[STAGES];
endmodule

// File: rtl/pm_wrap_counter.sv
module pm_wrap_counter #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_en_i,
    input  logic [CNT_W-1:0] reload_i,
    output logic [CNT_W-1:0] cnt_o,
    output logic             wrap_o,
    output logic [CNT_W:0]   lap_o
);
    logic [CNT_W-1:0] cnt_d, cnt_q;
    logic             wrap;

    // At or above reload also catches a reload lowered under the count.
    assign wrap = tick_en_i && (cnt_q >= reload_i);

    always_comb begin
        cnt_d = cnt_q;
        if (wrap)           cnt_d = '0;
        else if (tick_en_i) cnt_d = cnt_q + CNT_W'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign cnt_o  = cnt_q;
    assign wrap_o = wrap;
    // Ticks in the lap that ends now: equals reload + 1 with a steady reload.
    assign lap_o  = (CNT_W+1)'(cnt_q) + (CNT_W+1)'(1);
endmodule

// File: rtl/pm_period_engine.sv
module pm_period_engine #(
    parameter int CNT_W  = 16,
    parameter int WRAP_W = 16,
    parameter int PER_W  = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rise_i,
    input  logic             wrap_i,
    input  logic [CNT_W-1:0] cnt_i,
    input  logic [CNT_W:0]   lap_i,
    output logic [PER_W-1:0] period_o,
    output logic             valid_o,
    output logic [CNT_W-1:0] cap_o,
    output logic             sat_evt_o
);
    typedef struct packed {
        logic [PER_W-1:0]  acc;
        logic [WRAP_W-1:0] wraps;
        logic              sat;
        logic [CNT_W-1:0]  prev;
        logic [CNT_W-1:0]  cap;
        logic              primed;
        logic [PER_W-1:0]  period;
        logic              valid;
    } eng_st_t;

    eng_st_t st_d, st_q;
    logic    wraps_full;
    logic    wrap_late;

    assign wraps_full = &st_q.wraps;
    // A wrap in the capture cycle belongs to the next interval.
    assign wrap_late  = rise_i && wrap_i;

    always_comb begin
        st_d       = st_q;
        st_d.valid = 1'b0;
        sat_evt_o  = 1'b0;
        if (rise_i) begin
            st_d.cap    = cnt_i;
            st_d.prev   = cnt_i;
            st_d.primed = 1'b1;
            if (st_q.primed) begin
                st_d.valid  = 1'b1;
                st_d.period = st_q.sat ? '1
                            : st_q.acc + PER_W'(cnt_i) - PER_W'(st_q.prev);
            end
            st_d.sat   = 1'b0;
            st_d.acc   = wrap_late ? PER_W'(lap_i) : '0;
            st_d.wraps = wrap_late ? WRAP_W'(1) : '0;
        end else if (wrap_i) begin
            if (wraps_full) begin
                st_d.sat  = 1'b1;
                sat_evt_o = 1'b1;
            end else begin
                st_d.wraps = st_q.wraps + WRAP_W'(1);
                st_d.acc   = st_q.acc + PER_W'(lap_i);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign period_o = st_q.period;
    assign valid_o  = st_q.valid;
    assign cap_o    = st_q.cap;
endmodule

// File: rtl/pm_status_flags.sv
module pm_status_flags #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] set_i,
    input  logic         wr_i,
    input  logic [W-1:0] wmask_i,
    output logic [W-1:0] flags_o
);
    logic [W-1:0] flags_d, flags_q;

    always_comb begin
        // Zero bits of a write clear; a set in the same cycle wins.
        flags_d = (flags_q & (wr_i ? wmask_i : '1)) | set_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) flags_q <= '0;
        else        flags_q <= flags_d;
    end

    assign flags_o = flags_q;
endmodule

// File: rtl/period_meter.sv
module period_meter #(
    parameter int CNT_W       = 16,
    parameter int WRAP_W      = 16,
    parameter int PER_W       = 32,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_en,
    input  logic             cap_in,
    input  logic             reg_we,
    input  logic [1:0]       reg_addr,
    input  logic [CNT_W-1:0] reg_wdata,
    output logic [CNT_W-1:0] reg_rdata,
    output logic [PER_W-1:0] period_o,
    output logic             period_valid_o
);
    import pm_pkg::*;

    localparam logic [CNT_W-1:0] RELOAD_RST = '1;

    logic [CNT_W-1:0] reload_d, reload_q;
    logic             rise_w;
    logic             wrap_w;
    logic [CNT_W-1:0] cnt_w;
    logic [CNT_W:0]   lap_w;
    logic [CNT_W-1:0] cap_w;
    logic             sat_evt_w;
    logic [CNT_W-1:0] set_w;
    logic [CNT_W-1:0] flags_w;
    logic             stat_wr;

    always_comb begin
        reload_d = reload_q;
        if (reg_we && reg_addr == SEL_RELOAD) reload_d = reg_wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) reload_q <= RELOAD_RST;
        else        reload_q <= reload_d;
    end

    pm_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (cap_in),
        .rise_o  (rise_w)
    );

    pm_wrap_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick_en_i (tick_en),
        .reload_i  (reload_q),
        .cnt_o     (cnt_w),
        .wrap_o    (wrap_w),
        .lap_o     (lap_w)
    );

    pm_period_engine #(.CNT_W(CNT_W), .WRAP_W(WRAP_W), .PER_W(PER_W)) u_eng (
        .clk       (clk),
        .rst_n     (rst_n),
        .rise_i    (rise_w),
        .wrap_i    (wrap_w),
        .cnt_i     (cnt_w),
        .lap_i     (lap_w),
        .period_o  (period_o),
        .valid_o   (period_valid_o),
        .cap_o     (cap_w),
        .sat_evt_o (sat_evt_w)
    );

    always_comb begin
        set_w            = '0;
        set_w[FLAG_WRAP] = wrap_w;
        set_w[FLAG_CAP]  = rise_w;
        set_w[FLAG_SAT]  = sat_evt_w;
    end

    assign stat_wr = reg_we && reg_addr == SEL_STATUS;

    pm_status_flags #(.W(CNT_W)) u_flags (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_i   (set_w),
        .wr_i    (stat_wr),
        .wmask_i (reg_wdata),
        .flags_o (flags_w)
    );

    always_comb begin
        case (reg_addr)
            SEL_RELOAD:  reg_rdata = reload_q;
            SEL_STATUS:  reg_rdata = flags_w;
            SEL_CAPTURE: reg_rdata = cap_w;
            default:     reg_rdata = cnt_w;
        endcase
    end
endmodule

// File: rtl/pm_checker.sv
module pm_checker #(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             tick_en,
    input logic             reg_we,
    input logic [1:0]       reg_addr,
    input logic [CNT_W-1:0] reg_wdata,
    input logic [CNT_W-1:0] cnt,
    input logic [CNT_W-1:0] reload,
    input logic             wrap,
    input logic             rise,
    input logic [CNT_W-1:0] flags,
    input logic             period_valid
);
    import pm_pkg::*;

    AST_WRAP_TO_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        tick_en && cnt >= reload |=> cnt == '0); // R1
    AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        tick_en && cnt < reload |=> cnt == $past(cnt) + CNT_W'(1)); // R1
    AST_COUNT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        !tick_en |=> $stable(cnt)); // R1
    AST_VALID_FROM_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
        period_valid |-> $past(rise)); // R3
    AST_VALID_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        period_valid |=> !period_valid); // R5
    AST_ONE_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
        reg_we && reg_addr == SEL_STATUS && reg_wdata[FLAG_CAP] && flags[FLAG_CAP]
        |=> flags[FLAG_CAP]); // R6
    AST_ZERO_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        reg_we && reg_addr == SEL_STATUS && !reg_wdata[FLAG_CAP] && !rise
        |=> !flags[FLAG_CAP]); // R6
    AST_SET_BEATS_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        wrap |=> flags[FLAG_WRAP]); // R7
endmodule

bind period_meter pm_checker #(.CNT_W(CNT_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .tick_en      (tick_en),
    .reg_we       (reg_we),
    .reg_addr     (reg_addr),
    .reg_wdata    (reg_wdata),
    .cnt          (cnt_w),
    .reload       (reload_q),
    .wrap         (wrap_w),
    .rise         (rise_w),
    .flags        (flags_w),
    .period_valid (period_valid_o)
);

// File: tb/tb_period_meter.sv
`timescale 1ns/1ps
module tb_period_meter;
    import pm_pkg::*;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick_en = 1'b0;
    logic        cap_in = 1'b0;
    logic        reg_we = 1'b0;
    logic [1:0]  reg_addr = 2'd0;
    logic [15:0] reg_wdata = '0;
    logic [15:0] reg_rdata;
    logic [31:0] period_o;
    logic        period_valid_o;

    always #2.5 clk = ~clk;

    period_meter dut (
        .clk            (clk),
        .rst_n          (rst_n),
        .tick_en        (tick_en),
        .cap_in         (cap_in),
        .reg_we         (reg_we),
        .reg_addr       (reg_addr),
        .reg_wdata      (reg_wdata),
        .reg_rdata      (reg_rdata),
        .period_o       (period_o),
        .period_valid_o (period_valid_o)
    );

    int          n_chk = 0;
    int          n_fail = 0;
    int          tick_mode = 0;
    int          nvalid = 0;
    int          exp_valid = 0;
    int          races = 0;
    int          cur_reload = 16'hFFFF;
    bit          have_prev = 0;
    logic [31:0] t_prev = '0;
    logic [31:0] tcnt;
    logic [15:0] lfsr = 16'hACE1;
    logic [15:0] rv;

    // Tick pattern: off, steady, or pseudo-random.
    always @(negedge clk) begin
        lfsr    <= {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        tick_en <= (tick_mode == 1) ? 1'b1 : (tick_mode == 2) ? lfsr[0] : 1'b0;
    end

    // Elapsed enabled ticks, the time base of every expected period.
    always @(posedge clk or negedge rst_n) begin
        if (!rst_n)       tcnt <= '0;
        else if (tick_en) tcnt <= tcnt + 32'd1;
    end

    always @(negedge clk) if (rst_n && period_valid_o) nvalid++;

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic do_reset();
        tick_mode = 0;
        cap_in    = 1'b0;
        reg_we    = 1'b0;
        @(negedge clk) rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n     = 1'b1;
        have_prev = 0;
        nvalid    = 0;
        exp_valid = 0;
        cur_reload = 16'hFFFF;
    endtask

    task automatic wr(input logic [1:0] a, input logic [15:0] d, output logic [15:0] after);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(posedge clk);
        #1 after = reg_rdata;
        @(negedge clk) reg_we = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [15:0] d);
        @(negedge clk) reg_addr = a;
        #1 d = reg_rdata;
    endtask

    task automatic pulse(input int g, input bit sat_exp);
        logic [31:0] t_now;
        string       tag;
        int          hi;
        int          lo;
        hi = g / 2;
        lo = g - hi;
        @(negedge clk);
        cap_in = 1'b1; reg_addr = SEL_CAPTURE;
        @(posedge clk);
        @(posedge clk);
        #1 t_now = tcnt;
        @(posedge clk);
        #1;
        if (!have_prev) begin
            check("R5 first capture gives no strobe", 32'(period_valid_o), 32'd0);
        end else begin
            if (tick_mode == 1 && (t_now % 32'(cur_reload + 1)) == 32'(cur_reload)) begin
                tag = "R4 capture in wrap cycle";
                races++;
            end else begin
                tag = "R3 period";
            end
            check("R5 strobe on later capture", 32'(period_valid_o), 32'd1);
            check(tag, period_o, sat_exp ? 32'hFFFF_FFFF : t_now - t_prev);
            exp_valid++;
        end
        check("R2 capture register", 32'(reg_rdata), t_now % 32'(cur_reload + 1));
        t_prev    = t_now;
        have_prev = 1;
        repeat (hi - 2) @(negedge clk);
        cap_in = 1'b0;
        repeat (lo) @(negedge clk);
    endtask

    initial begin
        repeat (195000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual=running expected=finished");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        int rl[3];
        rl = '{3, 7, 12};
        do_reset();

        // R9 reset state
        rd(SEL_RELOAD, rv);  check("R9 reload after reset", 32'(rv), 32'hFFFF);
        rd(SEL_STATUS, rv);  check("R9 status after reset", 32'(rv), 32'd0);
        rd(SEL_CAPTURE, rv); check("R9 capture after reset", 32'(rv), 32'd0);
        rd(SEL_COUNT, rv);   check("R9 count after reset", 32'(rv), 32'd0);

        // R10 reload register
        wr(SEL_RELOAD, 16'd3, rv);
        cur_reload = 3;
        rd(SEL_RELOAD, rv);  check("R10 reload readback", 32'(rv), 32'd3);

        // R1 wrap modulo reload+1, then hold
        tick_mode = 1;
        repeat (10) @(negedge clk);
        tick_mode = 0;
        repeat (2) @(negedge clk);
        rd(SEL_COUNT, rv);   check("R1 count modulo lap", 32'(rv), tcnt % 32'd4);
        repeat (5) @(negedge clk);
        rd(SEL_COUNT, rv);   check("R1 count holds without tick", 32'(rv), tcnt % 32'd4);
        rd(SEL_STATUS, rv);  check("R6 wrap flag at bit 0", 32'(rv), 32'h0001);

        pulse(8, 0);
        rd(SEL_STATUS, rv);  check("R6 capture flag at bit 4", 32'(rv), 32'h0011);
        wr(SEL_STATUS, 16'hFFEF, rv);
        rd(SEL_STATUS, rv);  check("R6 0xFFEF clears only bit 4", 32'(rv), 32'h0001);
        wr(SEL_STATUS, 16'hFFFE, rv);
        rd(SEL_STATUS, rv);  check("R6 0xFFFE clears bit 0", 32'(rv), 32'h0000);

        // R7 set beats clear: reload 0 wraps on every tick
        do_reset();
        wr(SEL_RELOAD, 16'd0, rv);
        cur_reload = 0;
        tick_mode = 1;
        repeat (3) @(negedge clk);
        wr(SEL_STATUS, 16'hFFFE, rv);
        check("R7 wrap flag survives clear", 32'(rv[FLAG_WRAP]), 32'd1);
        tick_mode = 0;
        repeat (2) @(negedge clk);
        wr(SEL_STATUS, 16'hFFFE, rv);
        rd(SEL_STATUS, rv);  check("R6 idle clear of bit 0", 32'(rv[FLAG_WRAP]), 32'd0);

        // R3/R4 sweeps over gaps, reloads and tick patterns
        foreach (rl[i]) begin
            for (int mode = 1; mode <= 2; mode++) begin
                do_reset();
                wr(SEL_RELOAD, 16'(rl[i]), rv);
                cur_reload = rl[i];
                tick_mode = mode;
                for (int g = 6; g <= 30; g++) pulse(g, 0);
                repeat (4) @(negedge clk);
                check("R2 one strobe per rising edge only", 32'(nvalid), 32'(exp_valid));
            end
        end
        check("R4 wrap-cycle captures exercised", 32'(races > 0), 32'd1);

        // R8 saturation over a long interval
        do_reset();
        wr(SEL_RELOAD, 16'd0, rv);
        cur_reload = 0;
        tick_mode = 1;
        pulse(8, 0);
        repeat (65600) @(negedge clk);
        pulse(8, 1);
        rd(SEL_STATUS, rv);  check("R8 saturation flag bit 5", 32'(rv[FLAG_SAT]), 32'd1);
        pulse(12, 0);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule